// File: doc/BRIEF.md
# Tag-Tracking Out-of-Order Hazard Controller

This block is the central control of a small out-of-order core. It holds five functional units: an integer unit, a load unit, a store unit and two floating-point units. Each unit owns one status entry with its operation, its destination and source register numbers, and the producer tags of its two sources. A register status table records, for every architectural register, which unit will write it next. Instructions arrive in program order on a valid/ready dispatch port. Each one issues out of order once its sources are available. It retires once no older, not yet issued reader still needs the value it is about to overwrite.

Only tags are tracked. No operand value is copied at dispatch and nothing is forwarded between units. Sources are read from the register file at issue, and the register file is write-through in a retire cycle. The functional units are internal latency counters. Each computes `rs1 + rs2 + op` (modulo 2^DW) at issue. A small register file is included so that the order of reads and writes can be checked through a debug read port.

Each unit runs a four-state machine. The states are FU_IDLE (free), FU_WAIT (dispatched, waiting for its operands), FU_EXEC (counting down its latency) and FU_DONE (result held, waiting to retire). Its transitions are:
- alloc: FU_IDLE to FU_WAIT.
- issue: FU_WAIT to FU_EXEC, when both source tags are clear or are being cleared this cycle.
- finish: FU_EXEC to FU_DONE, when the count reaches one.
- retire: FU_DONE to FU_IDLE when the retire grant is given.
- retire with re-alloc: FU_DONE to FU_WAIT, when the unit is granted and takes a new instruction in the same cycle.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After reset, register i holds the value i, every unit is free and `disp_ready` is high for any dispatch.
- R2: `disp_cls` selects the unit class: 0 is the integer unit, 1 is load, 2 is store and 3 is floating point. A floating-point instruction takes the first free of the two floating-point units. Unit tags are 1 to 5, in the order integer, load, store, FP0, FP1. Tag 0 means that no write is pending.
- R3: `disp_ready` is low while no unit of the requested class is free. A unit that retires in a cycle can accept a new instruction in that same cycle.
- R4: A dispatch whose destination register already has a pending writer is stalled. A dispatch whose destination has no pending writer, or whose pending writer retires in that same cycle, is not stalled on this account. Store instructions have no destination.
- R5: A unit issues only when both of its source tags are clear. A producer retiring in a cycle releases its dependents to issue in that same cycle, and they read the written value. Operands are taken from the register file only.
- R6: A retiring write waits while any unissued instruction that was dispatched earlier still has to read the old value of that register. Final register contents equal those of sequential execution in program order.
- R7: A result is `rs1 + rs2 + op` modulo 2^DW and is written to the destination register. A store writes no register, and its `disp_rd` has no effect.
- R8: At most one unit retires per cycle. When several are ready, the unit with the lowest number retires first.
- R9: `dbg_rdata` shows the register selected by `dbg_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_cls | input | 2 | Unit class of the instruction |
| disp_op | input | OPW | Operation code, added into the result |
| disp_rd | input | AW | Destination register |
| disp_rs1 | input | AW | First source register |
| disp_rs2 | input | AW | Second source register |
| disp_ready | output | 1 | The dispatch is accepted this cycle |
| retire_valid | output | 1 | A unit retires this cycle |
| retire_tag | output | 3 | Tag of the retiring unit |
| rf_we | output | 1 | Register file write this cycle |
| rf_waddr | output | AW | Register being written |
| rf_wdata | output | DW | Value being written |
| dbg_raddr | input | AW | Debug read address |
| dbg_rdata | output | DW | Debug read data |

## Verification
The properties assume that dispatch fields stay stable while `disp_valid` is high and not yet accepted. They also assume that the register count is a power of two, so that every register number names a real register. The bench drives every input just after the falling edge and holds a request until it sees `disp_ready`. A probe withdraws its request before the next rising edge, so a request is never left half-issued. The random programs draw every field from the full legal range of its encoding, so no out-of-range value ever reaches the block.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUNIT   = 5;
    localparam int TAGW    = 3;
    localparam int U_ALU   = 0;
    localparam int U_LOAD  = 1;
    localparam int U_STORE = 2;
    localparam int U_FP0   = 3;
    localparam int U_FP1   = 4;

    typedef logic [TAGW-1:0] tag_t;

    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_STORE = 2'd2,
        CLS_FP    = 2'd3
    } fu_cls_e;

    typedef enum logic [1:0] {
        FU_IDLE = 2'd0,
        FU_WAIT = 2'd1,
        FU_EXEC = 2'd2,
        FU_DONE = 2'd3
    } fu_state_e;
endpackage

// File: rtl/sb_regfile.sv
module sb_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    output logic [NREG-1:0][DW-1:0]  q,
    output logic [NREG-1:0][DW-1:0]  view
);
    logic [NREG-1:0][DW-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= DW'(i);
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // write-through view used by issuing units
    always_comb begin
        view = mem_q;
        if (we) view[waddr] = wdata;
    end

    assign q = mem_q;
endmodule

// File: rtl/sb_fu_unit.sv
module sb_fu_unit
    import sb_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 8,
    parameter int OPW  = 4,
    parameter int LAT  = 1,
    localparam int AW  = $clog2(NREG),
    localparam int CW  = $clog2(LAT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc,
    input  logic [OPW-1:0]           a_op,
    input  logic [AW-1:0]            a_rd,
    input  logic [AW-1:0]            a_rs1,
    input  logic [AW-1:0]            a_rs2,
    input  tag_t                     a_t1,
    input  tag_t                     a_t2,
    input  logic                     bc_fire,
    input  tag_t                     bc_tag,
    input  logic                     grant,
    input  logic [NREG-1:0][DW-1:0]  rf_view,
    output fu_state_e                st,
    output logic [AW-1:0]            rd,
    output logic [AW-1:0]            rs1,
    output logic [AW-1:0]            rs2,
    output tag_t                     t1,
    output tag_t                     t2,
    output logic [DW-1:0]            result
);
    fu_state_e      st_q, st_d;
    logic [OPW-1:0] op_q;
    logic [AW-1:0]  rd_q, rs1_q, rs2_q;
    tag_t           t1_q, t2_q;
    logic [CW-1:0]  cnt_q;
    logic [DW-1:0]  res_q;
    logic           hit1, hit2, ops_ok;

    assign hit1   = bc_fire && (t1_q == bc_tag);
    assign hit2   = bc_fire && (t2_q == bc_tag);
    assign ops_ok = (t1_q == '0 || hit1) && (t2_q == '0 || hit2);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FU_IDLE: if (alloc) st_d = FU_WAIT;
            FU_WAIT: if (ops_ok) st_d = FU_EXEC;
            FU_EXEC: if (cnt_q == CW'(1)) st_d = FU_DONE;
            FU_DONE: if (grant) st_d = alloc ? FU_WAIT : FU_IDLE;
            default: st_d = FU_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FU_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            rd_q  <= '0;
            rs1_q <= '0;
            rs2_q <= '0;
            t1_q  <= '0;
            t2_q  <= '0;
            cnt_q <= '0;
            res_q <= '0;
        end else begin
            if (alloc) begin
                op_q  <= a_op;
                rd_q  <= a_rd;
                rs1_q <= a_rs1;
                rs2_q <= a_rs2;
                t1_q  <= a_t1;
                t2_q  <= a_t2;
            end else begin
                if (hit1) t1_q <= '0;
                if (hit2) t2_q <= '0;
            end
            if (st_q == FU_WAIT && st_d == FU_EXEC) begin
                cnt_q <= CW'(LAT);
                res_q <= rf_view[rs1_q] + rf_view[rs2_q] + DW'(op_q);
            end else if (st_q == FU_EXEC) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    assign st     = st_q;
    assign rd     = rd_q;
    assign rs1    = rs1_q;
    assign rs2    = rs2_q;
    assign t1     = t1_q;
    assign t2     = t2_q;
    assign result = res_q;
endmodule

// File: rtl/sb_prio_arb.sv
module sb_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
    import sb_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int DW        = 8,
    parameter int OPW       = 4,
    parameter int LAT_ALU   = 1,
    parameter int LAT_LOAD  = 2,
    parameter int LAT_STORE = 1,
    parameter int LAT_FP    = 3,
    localparam int AW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp_valid,
    input  logic [1:0]      disp_cls,
    input  logic [OPW-1:0]  disp_op,
    input  logic [AW-1:0]   disp_rd,
    input  logic [AW-1:0]   disp_rs1,
    input  logic [AW-1:0]   disp_rs2,
    output logic            disp_ready,
    output logic            retire_valid,
    output logic [2:0]      retire_tag,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    input  logic [AW-1:0]   dbg_raddr,
    output logic [DW-1:0]   dbg_rdata
);
    fu_state_e               st    [NUNIT];
    logic [AW-1:0]           u_rd  [NUNIT];
    logic [AW-1:0]           u_rs1 [NUNIT];
    logic [AW-1:0]           u_rs2 [NUNIT];
    tag_t                    u_t1  [NUNIT];
    tag_t                    u_t2  [NUNIT];
    logic [DW-1:0]           u_res [NUNIT];
    logic [NUNIT-1:0]        alloc, req, gnt, war_blk, unit_free;
    tag_t                    regstat_q [NREG];
    logic [NREG-1:0][DW-1:0] rf_q, rf_view;
    logic                    bc_fire, has_dest, tgt_free, waw_ok, disp_fire;
    logic [2:0]              gidx, tgt;
    tag_t                    bc_tag, eff_rd, eff_rs1, eff_rs2;

    // retire selection
    always_comb begin
        for (int i = 0; i < NUNIT; i++) begin
            war_blk[i] = 1'b0;
            if (i != U_STORE) begin
                for (int j = 0; j < NUNIT; j++) begin
                    if (j != i && st[j] == FU_WAIT &&
                        ((u_rs1[j] == u_rd[i] && u_t1[j] == '0) ||
                         (u_rs2[j] == u_rd[i] && u_t2[j] == '0)))
                        war_blk[i] = 1'b1;
                end
            end
            req[i] = (st[i] == FU_DONE) && !war_blk[i];
        end
    end

    sb_prio_arb #(.N(NUNIT)) u_arb (.req(req), .gnt(gnt));

    always_comb begin
        gidx = '0;
        for (int i = 0; i < NUNIT; i++) if (gnt[i]) gidx = 3'(i);
    end

    assign bc_fire      = |gnt;
    assign bc_tag       = bc_fire ? tag_t'(gidx + 3'd1) : '0;
    assign rf_we        = bc_fire && (gidx != 3'(U_STORE));
    assign rf_waddr     = u_rd[gidx];
    assign rf_wdata     = u_res[gidx];
    assign retire_valid = bc_fire;
    assign retire_tag   = bc_tag;

    // dispatch: tags as seen after this cycle's retire
    always_comb begin
        eff_rd  = (rf_we && rf_waddr == disp_rd)  ? '0 : regstat_q[disp_rd];
        eff_rs1 = (rf_we && rf_waddr == disp_rs1) ? '0 : regstat_q[disp_rs1];
        eff_rs2 = (rf_we && rf_waddr == disp_rs2) ? '0 : regstat_q[disp_rs2];
        for (int i = 0; i < NUNIT; i++)
            unit_free[i] = (st[i] == FU_IDLE) || (st[i] == FU_DONE && gnt[i]);
        unique case (fu_cls_e'(disp_cls))
            CLS_ALU:   tgt = 3'(U_ALU);
            CLS_LOAD:  tgt = 3'(U_LOAD);
            CLS_STORE: tgt = 3'(U_STORE);
            CLS_FP:    tgt = unit_free[U_FP0] ? 3'(U_FP0) : 3'(U_FP1);
            default:   tgt = 3'(U_ALU);
        endcase
        tgt_free = unit_free[tgt];
        has_dest = (fu_cls_e'(disp_cls) != CLS_STORE);
        waw_ok   = !has_dest || (eff_rd == '0);
        for (int i = 0; i < NUNIT; i++)
            alloc[i] = disp_fire && (tgt == 3'(i));
    end

    assign disp_ready = tgt_free && waw_ok;
    assign disp_fire  = disp_valid && disp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regstat_q[r] <= '0;
        end else begin
            if (rf_we) regstat_q[rf_waddr] <= '0;
            if (disp_fire && has_dest) regstat_q[disp_rd] <= tag_t'(tgt + 3'd1);
        end
    end

    sb_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr),
        .wdata(rf_wdata), .q(rf_q), .view(rf_view)
    );

    assign dbg_rdata = rf_q[dbg_raddr];

    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
        localparam int LAT_G = (g == U_ALU)   ? LAT_ALU  :
                               (g == U_LOAD)  ? LAT_LOAD :
                               (g == U_STORE) ? LAT_STORE : LAT_FP;
        sb_fu_unit #(.NREG(NREG), .DW(DW), .OPW(OPW), .LAT(LAT_G)) u_fu (
            .clk(clk), .rst_n(rst_n), .alloc(alloc[g]),
            .a_op(disp_op), .a_rd(disp_rd), .a_rs1(disp_rs1), .a_rs2(disp_rs2),
            .a_t1(eff_rs1), .a_t2(eff_rs2),
            .bc_fire(bc_fire), .bc_tag(bc_tag), .grant(gnt[g]), .rf_view(rf_view),
            .st(st[g]), .rd(u_rd[g]), .rs1(u_rs1[g]), .rs2(u_rs2[g]),
            .t1(u_t1[g]), .t2(u_t2[g]), .result(u_res[g])
        );
    end
endmodule

// File: rtl/sb_hazard_ctrl_chk.sv
module sb_hazard_ctrl_chk
    import sb_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input logic                     clk,
    input logic                     rst_n,
    input fu_state_e                st [NUNIT],
    input tag_t                     u_t1 [NUNIT],
    input tag_t                     u_t2 [NUNIT],
    input logic [NUNIT-1:0]         alloc,
    input logic [NUNIT-1:0]         gnt,
    input tag_t                     regstat [NREG],
    input logic [NREG-1:0][DW-1:0]  rf_q,
    input logic                     rf_we,
    input logic [AW-1:0]            rf_waddr,
    input tag_t                     bc_tag
);
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r4_writer_owns_reg: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> regstat[rf_waddr] == bc_tag);

    a_r6_rf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |=> $stable(rf_q));

    for (genvar g = 0; g < NUNIT; g++) begin : g_chk
        a_r5_exec_ops_clear: assert property (@(posedge clk) disable iff (!rst_n)
            st[g] == FU_EXEC |-> (u_t1[g] == '0 && u_t2[g] == '0));

        a_r3_alloc_waits: assert property (@(posedge clk) disable iff (!rst_n)
            alloc[g] |=> st[g] == FU_WAIT);
    end
endmodule

bind sb_hazard_ctrl sb_hazard_ctrl_chk #(.NREG(NREG), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .u_t1(u_t1), .u_t2(u_t2),
    .alloc(alloc), .gnt(gnt), .regstat(regstat_q), .rf_q(rf_q),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .bc_tag(bc_tag)
);

// File: tb/sb_hazard_ctrl_bench.sv
module sb_hazard_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [1:0] disp_cls = '0;
    logic [3:0] disp_op = '0;
    logic [2:0] disp_rd = '0, disp_rs1 = '0, disp_rs2 = '0;
    logic       disp_ready, retire_valid, rf_we;
    logic [2:0] retire_tag, rf_waddr;
    logic [7:0] rf_wdata, dbg_rdata;
    logic [2:0] dbg_raddr = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0] rf_m [8];
    logic [2:0] rlog [8];
    int  nlog = 0;
    bit  log_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    sb_hazard_ctrl u_sb_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_cls(disp_cls),
        .disp_op(disp_op), .disp_rd(disp_rd), .disp_rs1(disp_rs1), .disp_rs2(disp_rs2),
        .disp_ready(disp_ready), .retire_valid(retire_valid), .retire_tag(retire_tag),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk)
        if (rst_n && log_en && retire_valid && nlog < 8) begin
            rlog[nlog] = retire_tag;
            nlog++;
        end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic [3:0] op,
                         input logic [2:0] rd, input logic [2:0] a, input logic [2:0] b);
        disp_valid = 1'b1; disp_cls = c; disp_op = op;
        disp_rd = rd; disp_rs1 = a; disp_rs2 = b;
    endtask

    task automatic dispatch(input logic [1:0] c, input logic [3:0] op,
                            input logic [2:0] rd, input logic [2:0] a, input logic [2:0] b);
        @(negedge clk);
        drive(c, op, rd, a, b);
        #1;
        while (!disp_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        if (c != 2'd2) rf_m[rd] = rf_m[a] + rf_m[b] + 8'(op);
        #1 disp_valid = 1'b0;
    endtask

    // sample ready for one cycle without letting the request be taken
    task automatic probe(input logic [1:0] c, input logic [2:0] rd, output logic rdy);
        @(negedge clk);
        drive(c, 4'd0, rd, 3'd0, 3'd0);
        #1 rdy = disp_ready;
        disp_valid = 1'b0;
    endtask

    task automatic drain_and_compare(input string req);
        repeat (30) @(posedge clk);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            dbg_raddr = 3'(r);
            #1 check(req, dbg_rdata, rf_m[r]);
        end
    endtask

    initial begin
        logic rdy;
        for (int r = 0; r < 8; r++) rf_m[r] = 8'(r);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset contents seen through the R9 debug port
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            dbg_raddr = 3'(r);
            #1 check("R1/R9 reset reg", dbg_rdata, r);
        end
        probe(2'd0, 3'd1, rdy);
        check("R1 ready after reset", rdy, 1);

        // R4 WAW stall on pending destination
        dispatch(2'd3, 4'd1, 3'd3, 3'd1, 3'd2);
        probe(2'd1, 3'd3, rdy);
        check("R4 waw stall", rdy, 0);
        probe(2'd1, 3'd5, rdy);
        check("R4 other dest free", rdy, 1);
        drain_and_compare("R7 after waw");

        // R3 structural stall, other class unaffected
        dispatch(2'd0, 4'd2, 3'd1, 3'd2, 3'd3);
        probe(2'd0, 3'd6, rdy);
        check("R3 alu busy", rdy, 0);
        probe(2'd3, 3'd6, rdy);
        check("R3 fp free", rdy, 1);
        drain_and_compare("R7 after struct");

        // R2 two FP units, R3 third FP stalls
        dispatch(2'd3, 4'd3, 3'd1, 3'd4, 3'd5);
        probe(2'd3, 3'd2, rdy);
        check("R2 second fp free", rdy, 1);
        dispatch(2'd3, 4'd4, 3'd2, 3'd6, 3'd7);
        probe(2'd3, 3'd5, rdy);
        check("R3 both fp busy", rdy, 0);
        drain_and_compare("R2 fp results");

        // R7 store writes nothing
        dispatch(2'd2, 4'd5, 3'd7, 3'd1, 3'd2);
        drain_and_compare("R7 store ignored");

        // R8 load and FP become ready together; load retires first
        nlog = 0;
        log_en = 1;
        dispatch(2'd3, 4'd1, 3'd1, 3'd2, 3'd3);
        dispatch(2'd1, 4'd2, 3'd4, 3'd5, 3'd6);
        repeat (12) @(posedge clk);
        log_en = 0;
        check("R8 retire count", nlog, 2);
        check("R8 first retire tag", int'(rlog[0]), 2);
        check("R8 second retire tag", int'(rlog[1]), 4);
        drain_and_compare("R8 values");

        // R5 R6 R7 sequential-equivalence sweep
        for (int p = 0; p < 25; p++) begin
            for (int k = 0; k < 10; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                dispatch(lfsr[1:0], lfsr[14:11], lfsr[4:2], lfsr[7:5], lfsr[10:8]);
            end
            drain_and_compare("R5/R6 program order");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule